// File: doc/BRIEF.md
# Flash sector lock register unit

This block holds the program/erase lock state for the sectors of an embedded flash, split into a low space, a mid space and a high space. Three volatile lock registers drive the per-sector lock outputs: one covers the low and mid sectors, one covers the high sectors, and a secondary register can lock low sectors only. A lock bit of 1 means the sector is locked. Each volatile register is backed by a one-time-programmable image. The image leaves power-on fully locked, and a program to it can only clear bits. It can never be erased.

After a functional reset the unit copies the three images into the volatile registers in a single cycle and then raises `init_done`. From then on software may rewrite any volatile register with any value. A separate request port asks whether a program or erase to a given sector may proceed. The answer arrives one cycle after the request is accepted.

There are three request ports: volatile write, image program and sector access. Each uses a valid/ready handshake. A port accepts a beat on a clock edge where both valid and ready are high. All three ready signals follow `init_done`, so back-pressure exists only during reset and during the load cycle. A requester holds valid and its payload until the handshake completes.

Top module: `flash_lock_unit`

## Requirements
- R1: While `rst_n` is low, `init_done` is 0 and every lock output is 1. On the first rising edge after `rst_n` goes high, the volatile registers take the image values and `init_done` rises. `init_done` is still 0 between the release of `rst_n` and that edge.
- R2: An accepted image program with `nv_erase`=0 stores the old image ANDed with the write data. Selector codes: 0 = low/mid image, 1 = high image, 2 = secondary image. In the low/mid image, bits [NL-1:0] are the low sectors and bits [NL+NM-1:NL] are the mid sectors.
- R3: An image bit that has been cleared never returns to 1. An accepted image request with `nv_erase`=1 or selector 3 leaves all images unchanged and pulses `nv_err` high for exactly one cycle, starting in the cycle after acceptance.
- R4: An image program does not change the volatile registers or any lock output until the next reload that follows a reset.
- R5: An accepted volatile write with selector 0, 1 or 2 replaces the whole selected register, setting bits to 0 or 1 as given. The lock outputs show the new value from the next cycle. Selector 3 writes nothing.
- R6: `lock_low[i]` is the OR of low/mid register bit i and secondary register bit i. `lock_mid[j]` is low/mid register bit NL+j. `lock_high` is the high register.
- R7: An accepted access request gives a one-cycle `op_done` in the next cycle. That cycle carries `op_grant` if the target sector is unlocked and `op_acc_err` otherwise, and `op_done_erase` echoes `op_erase`. Space codes: 0 = low, 1 = mid, 2 = high. Space code 3, or an index at or beyond the sector count of the space, always gives `op_acc_err`.
- R8: `vw_ready`, `nv_ready` and `op_ready` are 0 during reset and during the load cycle, and 1 afterwards.
- R9: While `por_n` is low, every image bit returns to 1 (the delivery state). A functional reset alone leaves the images intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, puts the images in the delivery state |
| rst_n | input | 1 | Functional reset, active low, async |
| vw_valid | input | 1 | Volatile write request valid |
| vw_ready | output | 1 | Volatile write port ready |
| vw_sel | input | 2 | Volatile register selector |
| vw_data | input | DW | Volatile write data |
| nv_valid | input | 1 | Image request valid |
| nv_ready | output | 1 | Image port ready |
| nv_erase | input | 1 | Image request is an erase (always refused) |
| nv_sel | input | 2 | Image selector |
| nv_data | input | DW | Image program data |
| nv_err | output | 1 | One-cycle pulse for a refused image request |
| op_valid | input | 1 | Sector access request valid |
| op_ready | output | 1 | Access port ready |
| op_erase | input | 1 | Access is an erase (1) or a program (0) |
| op_space | input | 2 | Target address space |
| op_idx | input | IDX_W | Sector index within the space |
| op_done | output | 1 | Access response strobe |
| op_grant | output | 1 | Access allowed |
| op_acc_err | output | 1 | Access refused |
| op_done_erase | output | 1 | Echo of the accepted request's erase flag |
| lock_low | output | NL | Combined low-sector locks |
| lock_mid | output | NM | Mid-sector locks |
| lock_high | output | NH | High-sector locks |
| init_done | output | 1 | Reload complete |

## Verification
The bench programs an image repeatedly with overlapping masks, including an all-ones mask. A design that overwrote the image instead of ANDing it would appear to relock sectors after the next reset. The bench sends image erases and the reserved selector. A design that acted on them would raise bits or miss the `nv_err` pulse. It checks that image programs stay invisible until a reset. A design that wired the image straight to the outputs would change locks at once. Access probes cover sectors locked only by the secondary register, the last valid index, indices one past the end, and the reserved space code. A design that forgot the OR or the range check would grant access to a locked or nonexistent sector.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

  typedef enum logic [1:0] {
    REG_LM   = 2'd0,
    REG_HI   = 2'd1,
    REG_SEC  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SP_LOW  = 2'd0,
    SP_MID  = 2'd1,
    SP_HIGH = 2'd2,
    SP_BAD  = 2'd3
  } space_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/flash_lock_nvimg.sv
// One-time-programmable image: program only clears bits, nothing sets them
// except the power-on reset that models the delivery state.
module flash_lock_nvimg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         prog_en,
  input  logic [W-1:0] prog_data,
  output logic [W-1:0] image
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       image <= '1;
    else if (prog_en) image <= image & prog_data;
  end

endmodule

// File: rtl/flash_lock_vreg.sv
// Volatile lock register: resets locked, loads from its image once, then
// takes any software value.
module flash_lock_vreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '1;
    else if (load)  q <= load_val;
    else if (wr_en) q <= wr_data;
  end

endmodule

// File: rtl/flash_lock_gate.sv
// Looks up the lock of the addressed sector and registers the verdict.
module flash_lock_gate
  import flash_lock_pkg::*;
#(
  parameter int NL    = 8,
  parameter int NM    = 4,
  parameter int NH    = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             erase,
  input  logic [1:0]       space,
  input  logic [IDX_W-1:0] idx,
  input  logic [NL-1:0]    lock_low,
  input  logic [NM-1:0]    lock_mid,
  input  logic [NH-1:0]    lock_high,
  output logic             done,
  output logic             grant,
  output logic             acc_err,
  output logic             done_erase
);

  logic tgt_lock;

  // Anything not matched (bad space, index out of range) stays locked.
  always_comb begin
    tgt_lock = 1'b1;
    case (space)
      SP_LOW: begin
        for (int i = 0; i < NL; i++)
          if (idx == IDX_W'(i)) tgt_lock = lock_low[i];
      end
      SP_MID: begin
        for (int i = 0; i < NM; i++)
          if (idx == IDX_W'(i)) tgt_lock = lock_mid[i];
      end
      SP_HIGH: begin
        for (int i = 0; i < NH; i++)
          if (idx == IDX_W'(i)) tgt_lock = lock_high[i];
      end
      default: tgt_lock = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      grant      <= 1'b0;
      acc_err    <= 1'b0;
      done_erase <= 1'b0;
    end else begin
      done       <= accept;
      grant      <= accept && !tgt_lock;
      acc_err    <= accept && tgt_lock;
      done_erase <= accept && erase;
    end
  end

endmodule

// File: rtl/flash_lock_unit.sv
module flash_lock_unit
  import flash_lock_pkg::*;
#(
  parameter  int NL    = 8,
  parameter  int NM    = 4,
  parameter  int NH    = 8,
  localparam int LM_W  = NL + NM,
  localparam int DW    = (LM_W > NH) ? LM_W : NH,
  localparam int MAXN  = max3(NL, NM, NH),
  localparam int IDX_W = $clog2(MAXN) + 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             vw_valid,
  output logic             vw_ready,
  input  logic [1:0]       vw_sel,
  input  logic [DW-1:0]    vw_data,
  input  logic             nv_valid,
  output logic             nv_ready,
  input  logic             nv_erase,
  input  logic [1:0]       nv_sel,
  input  logic [DW-1:0]    nv_data,
  output logic             nv_err,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_erase,
  input  logic [1:0]       op_space,
  input  logic [IDX_W-1:0] op_idx,
  output logic             op_done,
  output logic             op_grant,
  output logic             op_acc_err,
  output logic             op_done_erase,
  output logic [NL-1:0]    lock_low,
  output logic [NM-1:0]    lock_mid,
  output logic [NH-1:0]    lock_high,
  output logic             init_done
);

  logic            vw_fire, nv_fire, op_fire, nv_prog;
  logic [LM_W-1:0] nv_lm, vol_lm;
  logic [NH-1:0]   nv_hi, vol_hi;
  logic [NL-1:0]   nv_sec, vol_sec;

  assign vw_ready = init_done;
  assign nv_ready = init_done;
  assign op_ready = init_done;
  assign vw_fire  = vw_valid && vw_ready;
  assign nv_fire  = nv_valid && nv_ready;
  assign op_fire  = op_valid && op_ready;
  assign nv_prog  = nv_fire && !nv_erase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_done <= 1'b0;
    else        init_done <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nv_err <= 1'b0;
    else        nv_err <= nv_fire && (nv_erase || nv_sel == REG_NONE);
  end

  flash_lock_nvimg #(.W(LM_W)) u_nv_lm (
    .clk(clk), .por_n(por_n),
    .prog_en(nv_prog && nv_sel == REG_LM),
    .prog_data(nv_data[LM_W-1:0]), .image(nv_lm));

  flash_lock_nvimg #(.W(NH)) u_nv_hi (
    .clk(clk), .por_n(por_n),
    .prog_en(nv_prog && nv_sel == REG_HI),
    .prog_data(nv_data[NH-1:0]), .image(nv_hi));

  flash_lock_nvimg #(.W(NL)) u_nv_sec (
    .clk(clk), .por_n(por_n),
    .prog_en(nv_prog && nv_sel == REG_SEC),
    .prog_data(nv_data[NL-1:0]), .image(nv_sec));

  flash_lock_vreg #(.W(LM_W)) u_vol_lm (
    .clk(clk), .rst_n(rst_n), .load(!init_done), .load_val(nv_lm),
    .wr_en(vw_fire && vw_sel == REG_LM),
    .wr_data(vw_data[LM_W-1:0]), .q(vol_lm));

  flash_lock_vreg #(.W(NH)) u_vol_hi (
    .clk(clk), .rst_n(rst_n), .load(!init_done), .load_val(nv_hi),
    .wr_en(vw_fire && vw_sel == REG_HI),
    .wr_data(vw_data[NH-1:0]), .q(vol_hi));

  flash_lock_vreg #(.W(NL)) u_vol_sec (
    .clk(clk), .rst_n(rst_n), .load(!init_done), .load_val(nv_sec),
    .wr_en(vw_fire && vw_sel == REG_SEC),
    .wr_data(vw_data[NL-1:0]), .q(vol_sec));

  assign lock_low  = vol_lm[NL-1:0] | vol_sec;
  assign lock_mid  = vol_lm[LM_W-1:NL];
  assign lock_high = vol_hi;

  flash_lock_gate #(.NL(NL), .NM(NM), .NH(NH), .IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .accept(op_fire), .erase(op_erase),
    .space(op_space), .idx(op_idx),
    .lock_low(lock_low), .lock_mid(lock_mid), .lock_high(lock_high),
    .done(op_done), .grant(op_grant), .acc_err(op_acc_err),
    .done_erase(op_done_erase));

endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk #(
  parameter int NL = 8,
  parameter int NM = 4,
  parameter int NH = 8,
  parameter int DW = 12
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             init_done,
  input logic             nv_fire,
  input logic             nv_erase,
  input logic [1:0]       nv_sel,
  input logic [DW-1:0]    nv_data,
  input logic             nv_err,
  input logic [NL+NM-1:0] nv_img_lm,
  input logic [NH-1:0]    nv_img_hi,
  input logic [NL-1:0]    nv_img_sec,
  input logic [NL+NM-1:0] vol_lm,
  input logic [NH-1:0]    vol_hi,
  input logic [NL-1:0]    vol_sec,
  input logic             op_fire,
  input logic             op_done,
  input logic             op_grant,
  input logic             op_acc_err,
  input logic [NL-1:0]    lock_low,
  input logic [NM-1:0]    lock_mid,
  input logic [NH-1:0]    lock_high
);

  assert_locked_in_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (&lock_low && &lock_mid && &lock_high));

  assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(init_done) |-> (vol_lm == nv_img_lm && vol_hi == nv_img_hi && vol_sec == nv_img_sec));

  assert_prog_and_R2: assert property (@(posedge clk) disable iff (!por_n)
    (nv_fire && !nv_erase && nv_sel == 2'd0) |=>
      nv_img_lm == ($past(nv_img_lm) & $past(nv_data[NL+NM-1:0])));

  assert_no_raise_R3: assert property (@(posedge clk) disable iff (!por_n)
    ((~$past(nv_img_lm) & nv_img_lm) == '0) && ((~$past(nv_img_hi) & nv_img_hi) == '0) &&
    ((~$past(nv_img_sec) & nv_img_sec) == '0));

  assert_erase_flag_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (nv_fire && nv_erase) |=> nv_err);

  assert_erase_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    (nv_fire && nv_erase) |=> ($stable(nv_img_lm) && $stable(nv_img_hi) && $stable(nv_img_sec)));

  assert_resp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> op_done);

  assert_resp_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> $past(op_fire));

  assert_resp_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_grant && op_acc_err));

endmodule

bind flash_lock_unit flash_lock_chk #(.NL(NL), .NM(NM), .NH(NH), .DW(DW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .init_done(init_done),
  .nv_fire(nv_fire), .nv_erase(nv_erase), .nv_sel(nv_sel), .nv_data(nv_data),
  .nv_err(nv_err), .nv_img_lm(nv_lm), .nv_img_hi(nv_hi), .nv_img_sec(nv_sec),
  .vol_lm(vol_lm), .vol_hi(vol_hi), .vol_sec(vol_sec),
  .op_fire(op_fire), .op_done(op_done), .op_grant(op_grant), .op_acc_err(op_acc_err),
  .lock_low(lock_low), .lock_mid(lock_mid), .lock_high(lock_high));

// File: tb/flash_lock_unit_tb.sv
module flash_lock_unit_tb;

  localparam int CLK_P = 10;
  localparam int NL = 8, NM = 4, NH = 8, DW = 12, IDX_W = 4;

  // vector: {space[1:0], idx[3:0], erase, expected grant}
  localparam int NV = 13;
  localparam logic [7:0] VEC [NV] = '{
    {2'd0, 4'd0, 1'b0, 1'b0},  // low 0 locked by low/mid reg
    {2'd0, 4'd1, 1'b1, 1'b1},  // low 1 free
    {2'd0, 4'd4, 1'b0, 1'b0},  // low 4 locked only by secondary
    {2'd0, 4'd6, 1'b1, 1'b1},  // low 6 free
    {2'd0, 4'd7, 1'b0, 1'b0},  // last low locked
    {2'd0, 4'd8, 1'b0, 1'b0},  // one past low end
    {2'd1, 4'd0, 1'b1, 1'b1},  // mid 0 free
    {2'd1, 4'd3, 1'b0, 1'b1},  // last mid free
    {2'd1, 4'd4, 1'b0, 1'b0},  // one past mid end
    {2'd2, 4'd0, 1'b0, 1'b0},  // high 0 locked
    {2'd2, 4'd3, 1'b1, 1'b1},  // high 3 free
    {2'd2, 4'd7, 1'b0, 1'b0},  // high 7 locked
    {2'd3, 4'd1, 1'b0, 1'b0}   // reserved space
  };

  logic clk = 1'b0;
  logic por_n, rst_n;
  logic vw_valid, vw_ready;
  logic [1:0] vw_sel;
  logic [DW-1:0] vw_data;
  logic nv_valid, nv_ready, nv_erase, nv_err;
  logic [1:0] nv_sel;
  logic [DW-1:0] nv_data;
  logic op_valid, op_ready, op_erase, op_done, op_grant, op_acc_err, op_done_erase;
  logic [1:0] op_space;
  logic [IDX_W-1:0] op_idx;
  logic [NL-1:0] lock_low;
  logic [NM-1:0] lock_mid;
  logic [NH-1:0] lock_high;
  logic init_done;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_lock_unit #(.NL(NL), .NM(NM), .NH(NH)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .vw_valid(vw_valid), .vw_ready(vw_ready), .vw_sel(vw_sel), .vw_data(vw_data),
    .nv_valid(nv_valid), .nv_ready(nv_ready), .nv_erase(nv_erase), .nv_sel(nv_sel),
    .nv_data(nv_data), .nv_err(nv_err),
    .op_valid(op_valid), .op_ready(op_ready), .op_erase(op_erase), .op_space(op_space),
    .op_idx(op_idx), .op_done(op_done), .op_grant(op_grant), .op_acc_err(op_acc_err),
    .op_done_erase(op_done_erase),
    .lock_low(lock_low), .lock_mid(lock_mid), .lock_high(lock_high),
    .init_done(init_done));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_locks(input string tag, input logic [NL-1:0] lo,
                           input logic [NM-1:0] mi, input logic [NH-1:0] hi);
    chk({tag, " lock_low"},  32'(lock_low),  32'(lo));
    chk({tag, " lock_mid"},  32'(lock_mid),  32'(mi));
    chk({tag, " lock_high"}, 32'(lock_high), 32'(hi));
  endtask

  task automatic vwrite(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    vw_valid = 1'b1; vw_sel = sel; vw_data = d;
    @(negedge clk);
    vw_valid = 1'b0;
  endtask

  task automatic nvreq(input logic [1:0] sel, input logic [DW-1:0] d, input logic er,
                       input logic exp_err, input string tag);
    @(negedge clk);
    nv_valid = 1'b1; nv_sel = sel; nv_data = d; nv_erase = er;
    @(negedge clk);
    nv_valid = 1'b0; nv_erase = 1'b0;
    chk({tag, " nv_err pulse"}, 32'(nv_err), 32'(exp_err));
    @(negedge clk);
    chk({tag, " nv_err clears"}, 32'(nv_err), 32'd0);
  endtask

  task automatic func_reset(input logic with_por);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    @(negedge clk);
    chk("R1 init_done low in reset", 32'(init_done), 32'd0);
    chk("R8 ready low in reset", {29'd0, vw_ready, nv_ready, op_ready}, 32'd0);
    chk_locks("R1 reset", '1, '1, '1);
    rst_n = 1'b1; por_n = 1'b1;
    #1;
    chk("R1 init_done low before load edge", 32'(init_done), 32'd0);
    @(negedge clk);
    chk("R1 init_done after load", 32'(init_done), 32'd1);
    chk("R8 ready after load", {29'd0, vw_ready, nv_ready, op_ready}, 32'd7);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0;
    vw_valid = 1'b0; vw_sel = '0; vw_data = '0;
    nv_valid = 1'b0; nv_sel = '0; nv_data = '0; nv_erase = 1'b0;
    op_valid = 1'b0; op_erase = 1'b0; op_space = '0; op_idx = '0;
    repeat (3) @(negedge clk);
    func_reset(1'b1);
    chk_locks("R9 delivery state", '1, '1, '1);

    // Image programming is invisible until reload.
    nvreq(2'd0, 12'hF0F, 1'b0, 1'b0, "R2 prog lm");
    chk_locks("R4 no effect before reset", '1, '1, '1);
    nvreq(2'd0, 12'hFF0, 1'b0, 1'b0, "R2 prog lm again");
    nvreq(2'd0, 12'hFFF, 1'b0, 1'b0, "R3 prog ones");
    nvreq(2'd0, 12'h000, 1'b1, 1'b1, "R3 erase lm");
    nvreq(2'd1, 12'h03C, 1'b0, 1'b0, "R2 prog hi");
    nvreq(2'd2, 12'h00F, 1'b0, 1'b0, "R2 prog sec");
    nvreq(2'd3, 12'h000, 1'b0, 1'b1, "R3 reserved sel");
    chk_locks("R4 still locked", '1, '1, '1);

    // Reload: lm image = F0F & FF0 = F00, secondary 0F, high 3C.
    func_reset(1'b0);
    chk_locks("R2 R3 R6 reload", 8'h0F, 4'hF, 8'h3C);

    vwrite(2'd2, 12'h000);
    chk_locks("R5 R6 clear secondary", 8'h00, 4'hF, 8'h3C);
    vwrite(2'd0, 12'hFFF);
    chk_locks("R5 relock lm", 8'hFF, 4'hF, 8'h3C);
    vwrite(2'd0, 12'h0A5);
    vwrite(2'd2, 12'h010);
    vwrite(2'd1, 12'h081);
    chk_locks("R5 R6 set state", 8'hB5, 4'h0, 8'h81);
    vwrite(2'd3, 12'h000);
    chk_locks("R5 reserved sel ignored", 8'hB5, 4'h0, 8'h81);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      op_valid = 1'b1;
      op_space = VEC[k][7:6];
      op_idx   = VEC[k][5:2];
      op_erase = VEC[k][1];
      @(negedge clk);
      op_valid = 1'b0;
      chk($sformatf("R7 vec %0d done", k), 32'(op_done), 32'd1);
      chk($sformatf("R7 vec %0d grant", k), 32'(op_grant), 32'(VEC[k][0]));
      chk($sformatf("R7 vec %0d acc_err", k), 32'(op_acc_err), 32'(!VEC[k][0]));
      chk($sformatf("R7 vec %0d erase echo", k), 32'(op_done_erase), 32'(VEC[k][1]));
    end
    @(negedge clk);
    chk("R7 done is one cycle", 32'(op_done), 32'd0);

    // Functional reset keeps images; power-on reset restores delivery state.
    func_reset(1'b0);
    chk_locks("R9 images survive reset", 8'h0F, 4'hF, 8'h3C);
    func_reset(1'b1);
    chk_locks("R9 por restores locked", '1, '1, '1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule